// File: doc/BRIEF.md
# Conversion Sequencer with Mode-Selected Result Latching

This block is the digital controller of a successive-approximation converter. An active-low convert-start input is synchronised into the clock domain. Its falling edge starts a conversion. While the conversion runs, an active-high-idle busy output stays low for a fixed number of clock cycles, set by a parameter. The bit search itself is not modelled. Its outcome is a result word, supplied on a stimulus input and captured when the count runs out.

Two mode inputs choose when that result reaches the output register. In the first mode it is written at the end of the conversion, on the same edge at which busy returns high. In the second mode busy returns high right away, but the result waits in a hidden holding register. It is moved to the output register only when the next conversion is accepted, so the bus always shows the previous sample. The output bus is enabled only while chip-select and read are both low. Chip-select may therefore be tied low. An asynchronous active-low reset aborts any conversion in progress.

Top module: `sar_conv_sequencer`

## Requirements
- R1: A falling edge on `convst_n` is accepted two clock edges after the input is first seen low. This allows for a 2-stage synchroniser. `busy` goes low after the third rising edge.
- R2: `busy` stays low for exactly `CONV_CYCLES` clock cycles (30 by default) for every accepted conversion.
- R3: `mode_sel` encodes the latching mode. `2'b01` means latch at end of conversion. `2'b10` means deferred latch. The mode is sampled when the start edge is accepted.
- R4: In mode `2'b01`, the output register takes `sar_word` on the edge where `busy` rises. The new value is readable as soon as `busy` is high.
- R5: In mode `2'b10`, the output register is unchanged when `busy` rises. The held result is copied to the output register on the edge that accepts the next conversion, which is the same edge where `busy` falls.
- R6: `dout_en` is 1 exactly when `cs_n` and `rd_n` are both 0. `dout` shows the output register while `dout_en` is 1 and reads all zeros otherwise.
- R7: While `rst_n` is low, any running conversion is aborted and `busy` is 1. The output register is 0, a held deferred result is discarded and `mode_err` is 0. Start edges seen while reset is held are ignored.
- R8: A start edge accepted while `mode_sel` is `2'b00` or `2'b11` does not start a conversion, and it sets `mode_err`. The next accepted legal start clears `mode_err`.
- R9: A start edge that arrives while `busy` is low is ignored. The running conversion ends at its original time and no new one follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; aborts a conversion |
| convst_n | input | 1 | Convert start; falling edge begins a conversion |
| mode_sel | input | 2 | Latching mode select, 01 or 10 legal |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read |
| sar_word | input | DATA_W | Result word captured at the end of the conversion count |
| busy | output | 1 | Low while a conversion runs |
| mode_err | output | 1 | Set by a start edge with an illegal mode |
| dout_en | output | 1 | Bus drive enable |
| dout | output | DATA_W | Output register value while enabled, zero otherwise |

## Verification
The bench looks at the exact edge where `busy` falls and rises. A wrong synchroniser depth would shift the first of these, and an off-by-one counter would shift the second. In deferred mode the bench follows the one-sample lag across a run of words. A design that latched at the end of the conversion would show the current word too early, and one that never cleared its holding register would replay a stale value after a reset or a mode change. The bench also retriggers during a busy period, which a careless design would relaunch or stretch. It uses illegal modes, which such a design might launch anyway. It aborts a conversion with reset, after which a faulty design could still finish and write the result register.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
   localparam logic [1:0] MODE_AT_END  = 2'b01;
   localparam logic [1:0] MODE_DEFER   = 2'b10;

   function automatic logic mode_legal(input logic [1:0] m);
      return (m == MODE_AT_END) || (m == MODE_DEFER);
   endfunction
endpackage

// File: rtl/seq_start_sync.sv
module seq_start_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_n_i,
   output logic fall_o
);
   if (STAGES < 1) begin : g_bad_stages
      $error("seq_start_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= 1'b1;
      else        chain_q[0] <= start_n_i;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[i] <= 1'b1;
         else        chain_q[i] <= chain_q[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign fall_o = prev_q & ~chain_q[STAGES-1];

   // R1: an edge pulse lasts a single cycle
   a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |=> !fall_o);
endmodule

// File: rtl/seq_conv_timer.sv
module seq_conv_timer #(
   parameter int CYCLES = 30
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch_i,
   output logic running_o,
   output logic done_o
);
   if (CYCLES < 1) begin : g_bad_cycles
      $error("seq_conv_timer: CYCLES must be at least 1");
   end

   localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
   localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

   logic [CW-1:0] cnt_q;
   logic          run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
      end else if (run_q) begin
         if (cnt_q == '0) run_q <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end else if (launch_i) begin
         run_q <= 1'b1;
         cnt_q <= LOAD;
      end
   end

   assign running_o = run_q;
   assign done_o    = run_q && (cnt_q == '0);

   // R2: a conversion cannot end while count remains
   a_r2_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && cnt_q != '0) |=> run_q);
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
   import sar_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       fall_i,
   input  logic       running_i,
   input  logic [1:0] mode_i,
   output logic       launch_o,
   output logic [1:0] mode_q,
   output logic       err_o
);
   logic idle_edge;
   assign idle_edge = fall_i & ~running_i;
   assign launch_o  = idle_edge & mode_legal(mode_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_AT_END;
         err_o  <= 1'b0;
      end else if (idle_edge) begin
         if (mode_legal(mode_i)) begin
            mode_q <= mode_i;
            err_o  <= 1'b0;
         end else begin
            err_o  <= 1'b1;
         end
      end
   end

   // R8: illegal mode raises the flag and starts nothing
   a_r8_illegal_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_edge && !mode_legal(mode_i)) |=> (err_o && !running_i));
   // R9: edges during a conversion touch no control state
   a_r9_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_i && running_i) |=> ($stable(mode_q) && $stable(err_o)));
endmodule

// File: rtl/seq_result_reg.sv
module seq_result_reg #(
   parameter int DATA_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch_i,
   input  logic              done_i,
   input  logic              defer_i,
   input  logic [DATA_W-1:0] word_i,
   output logic [DATA_W-1:0] out_q
);
   if (DATA_W < 1) begin : g_bad_width
      $error("seq_result_reg: DATA_W must be at least 1");
   end

   logic [DATA_W-1:0] hold_q;
   logic              hold_vld_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q      <= '0;
         hold_q     <= '0;
         hold_vld_q <= 1'b0;
      end else if (done_i) begin
         if (defer_i) begin
            hold_q     <= word_i;
            hold_vld_q <= 1'b1;
         end else begin
            out_q      <= word_i;
            hold_vld_q <= 1'b0;
         end
      end else if (launch_i && hold_vld_q) begin
         out_q      <= hold_q;
         hold_vld_q <= 1'b0;
      end
   end

   // R4: end-of-conversion mode writes the word
   a_r4_load_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !defer_i) |=> (out_q == $past(word_i)));
   // R5: deferred mode leaves the output alone at completion
   a_r5_defer_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && defer_i) |=> $stable(out_q));
endmodule

// File: rtl/seq_bus_drive.sv
module seq_bus_drive #(
   parameter int DATA_W    = 15,
   parameter bit IDLE_ZERO = 1'b1
) (
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic [DATA_W-1:0] data_i,
   output logic              en_o,
   output logic [DATA_W-1:0] data_o
);
   assign en_o = ~cs_n & ~rd_n;

   if (IDLE_ZERO) begin : g_gated
      assign data_o = en_o ? data_i : '0;
   end else begin : g_open
      assign data_o = data_i;
   end
endmodule

// File: rtl/sar_conv_sequencer.sv
module sar_conv_sequencer
   import sar_seq_pkg::*;
#(
   parameter int DATA_W      = 15,
   parameter int CONV_CYCLES = 30,
   parameter int SYNC_STAGES = 2,
   parameter bit IDLE_ZERO   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              convst_n,
   input  logic [1:0]        mode_sel,
   input  logic              cs_n,
   input  logic              rd_n,
   input  logic [DATA_W-1:0] sar_word,
   output logic              busy,
   output logic              mode_err,
   output logic              dout_en,
   output logic [DATA_W-1:0] dout
);
   logic              start_fall;
   logic              launch;
   logic              running;
   logic              done;
   logic [1:0]        mode_q;
   logic [DATA_W-1:0] result_q;

   seq_start_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .start_n_i(convst_n), .fall_o(start_fall));

   seq_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .fall_i(start_fall), .running_i(running),
      .mode_i(mode_sel), .launch_o(launch), .mode_q(mode_q), .err_o(mode_err));

   seq_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .launch_i(launch),
      .running_o(running), .done_o(done));

   seq_result_reg #(.DATA_W(DATA_W)) u_result (
      .clk(clk), .rst_n(rst_n), .launch_i(launch), .done_i(done),
      .defer_i(mode_q == MODE_DEFER), .word_i(sar_word), .out_q(result_q));

   seq_bus_drive #(.DATA_W(DATA_W), .IDLE_ZERO(IDLE_ZERO)) u_bus (
      .cs_n(cs_n), .rd_n(rd_n), .data_i(result_q),
      .en_o(dout_en), .data_o(dout));

   assign busy = ~running;

   // checker: length of the current low stretch of busy
   logic [31:0] low_len_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     low_len_q <= '0;
      else if (!busy) low_len_q <= low_len_q + 1'b1;
      else            low_len_q <= '0;
   end

   // R1: an accepted edge pulls busy low on the next cycle
   a_r1_busy_falls: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> !busy);
   // R2: every completed busy period has the programmed length
   a_r2_busy_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (low_len_q == 32'(CONV_CYCLES)));
   // R6: enabled bus shows the output register
   a_r6_bus_value: assert property (@(posedge clk) disable iff (!rst_n)
      dout_en |-> (dout == result_q));
endmodule

// File: tb/sar_conv_sequencer_test.sv
module sar_conv_sequencer_test;
   localparam int DW = 15;
   localparam int CC = 30;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          convst_n = 1'b1;
   logic [1:0]    mode_sel = 2'b01;
   logic          cs_n = 1'b0;
   logic          rd_n = 1'b0;
   logic [DW-1:0] sar_word = '0;
   logic          busy, mode_err, dout_en;
   logic [DW-1:0] dout;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   logic [DW-1:0] exp_out = '0;
   logic [DW-1:0] hold = '0;
   bit            hold_vld = 0;

   always #5 clk = ~clk;

   sar_conv_sequencer #(.DATA_W(DW), .CONV_CYCLES(CC)) uut (
      .clk(clk), .rst_n(rst_n), .convst_n(convst_n), .mode_sel(mode_sel),
      .cs_n(cs_n), .rd_n(rd_n), .sar_word(sar_word), .busy(busy),
      .mode_err(mode_err), .dout_en(dout_en), .dout(dout));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // called at a falling clock edge; returns at the second falling edge after
   task automatic start_pulse();
      convst_n = 1'b0;
      tick(2);
      convst_n = 1'b1;
   endtask

   // full legal conversion; checks R1, R2, R4, R5 timing and values
   task automatic run_conv(input logic [1:0] m, input logic [DW-1:0] w);
      mode_sel = m;
      sar_word = w;
      start_pulse();
      chk("R1 busy before accept", busy, 1);
      tick(1);
      chk("R1 busy low after accept", busy, 0);
      if (hold_vld) begin
         exp_out  = hold;
         hold_vld = 0;
      end
      chk("R5 copy on next start", dout, exp_out);
      chk("R8 err cleared by legal start", mode_err, 0);
      tick(CC - 1);
      chk("R2 busy still low at last cycle", busy, 0);
      tick(1);
      chk("R2 busy high after count", busy, 1);
      if (m == 2'b01) begin
         exp_out  = w;
         hold_vld = 0;
      end else begin
         hold     = w;
         hold_vld = 1;
      end
      chk(m == 2'b01 ? "R4 result at busy rise" : "R5 output held at busy rise",
          dout, exp_out);
      tick(2);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      tick(3);
      // R7 reset state
      chk("R7 busy in reset", busy, 1);
      chk("R7 output zero in reset", dout, 0);
      chk("R7 err clear in reset", mode_err, 0);
      rst_n = 1'b1;
      tick(2);

      // R4 mode 01 sweep over computed words, including extremes (R3)
      for (int i = 0; i < 8; i++) run_conv(2'b01, DW'((i * 4973 + 32'h1234) & 32'h7FFF));
      run_conv(2'b01, '1);
      run_conv(2'b01, '0);

      // R5 mode 10 sequence: one-sample lag (R3)
      for (int i = 0; i < 6; i++) run_conv(2'b10, DW'((i * 7919 + 32'h0ABC) & 32'h7FFF));
      // switching back to mode 01 flushes the held word first
      run_conv(2'b01, 15'h2AAA);

      // R6 bus enable over all four select combinations
      for (int c = 0; c < 2; c++) begin
         for (int r = 0; r < 2; r++) begin
            cs_n = c[0];
            rd_n = r[0];
            tick(1);
            chk("R6 dout_en", dout_en, (c == 0 && r == 0) ? 1 : 0);
            chk("R6 dout", dout, (c == 0 && r == 0) ? exp_out : 0);
         end
      end
      cs_n = 1'b0;
      rd_n = 1'b0;
      tick(1);

      // R9 retrigger during busy is ignored
      mode_sel = 2'b01;
      sar_word = 15'h1357;
      start_pulse();
      tick(1);
      chk("R9 first start accepted", busy, 0);
      tick(2);
      start_pulse();
      tick(CC - 5);
      chk("R9 busy low at original end-1", busy, 0);
      tick(1);
      chk("R9 busy high at original end", busy, 1);
      exp_out = 15'h1357;
      chk("R9 result of first conversion", dout, exp_out);
      tick(5);
      chk("R9 no relaunch", busy, 1);

      // R8 illegal modes
      for (int k = 0; k < 2; k++) begin
         mode_sel = (k == 0) ? 2'b00 : 2'b11;
         sar_word = 15'h0F0F;
         start_pulse();
         tick(1);
         chk("R8 illegal start not launched", busy, 1);
         chk("R8 err set", mode_err, 1);
         tick(CC + 2);
         chk("R8 output untouched", dout, exp_out);
      end
      run_conv(2'b01, 15'h0321);

      // R7 abort with reset, deferred word discarded
      run_conv(2'b10, 15'h4444);
      mode_sel = 2'b01;
      sar_word = 15'h7777;
      start_pulse();
      tick(6);
      rst_n = 1'b0;
      tick(1);
      chk("R7 abort raises busy", busy, 1);
      chk("R7 abort clears output", dout, 0);
      start_pulse();
      tick(4);
      chk("R7 start ignored in reset", busy, 1);
      rst_n = 1'b1;
      tick(CC + 10);
      chk("R7 aborted conversion never completes", dout, 0);
      exp_out  = '0;
      hold_vld = 0;
      run_conv(2'b10, 15'h0055);
      chk("R7 held word discarded by reset", dout, 0);
      run_conv(2'b10, 15'h00AA);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule